// File: doc/BRIEF.md
# Elastic Bit Store with Fill-Driven Read-Rate Loop

This block is a single-bit circular buffer that sits between a tributary writer and a locally timed reader. The writer offers one bit per cycle on a write enable. The reader's timing comes from a phase accumulator inside the block, which adds a tuning word on every system clock and issues a read each time the sum carries out of its top bit. All of it runs on one system clock; the rates on both sides are expressed as enable pulses.

The number of unread bits is found by subtracting the read pointer from the write pointer modulo the buffer depth. That occupancy is also the error signal of a small digital control loop. At a fixed interval the block compares the current occupancy with the value it sampled one interval earlier. It then moves the tuning word one step toward the writer's rate, so the synthesized read rate settles at the incoming bit rate. After reset, reading is held off until the buffer is half full, which leaves margin on both sides.

Top module: `esp_elastic_store`

## Requirements
- R1: The occupancy output `fill` equals (write pointer − read pointer) modulo 1024, taken as a 10-bit unsigned value with any borrow discarded. Pointers at 489/241 give 248. Pointers at 127/890, which straddle address 0, give 261.
- R2: Bits come out on `rd_bit` in the order they were accepted. Each accepted read raises `rd_vld` for exactly one cycle, on the clock edge after the read is taken.
- R3: A 24-bit phase accumulator adds `tune_word` on every clock, and a read can only happen in a cycle where that addition carries out. A tuning word of 0x800000 yields one read every two clocks.
- R4: After reset no read happens until `fill` has first reached 512. From then on reads stay enabled until the next reset.
- R5: Every 256 clocks the current `fill` is compared with the sample taken 256 clocks earlier, and the comparison only acts once reads are enabled. A higher fill raises `tune_word` by 1, a lower fill lowers it by 1, and an equal fill leaves it unchanged.
- R6: On every clock `tune_word` is held inside [`cfg_tune_min`, `cfg_tune_max`]. Narrowing the range pulls the word into it on the next edge.
- R7: A write offered while `fill` is 1023 is dropped, so `fill` does not change on its account. The offer sets `ovf_flag`, which then stays set until reset.
- R8: A read strobe that arrives while `fill` is 0 is dropped and gives no `rd_vld`. It sets `udf_flag`, which then stays set until reset.
- R9: During and right after reset, `fill` is 0, `rd_vld`, `ovf_flag` and `udf_flag` are 0, and `tune_word` equals `cfg_tune_nom`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Offer one tributary bit this cycle |
| wr_bit | input | 1 | Tributary bit value |
| cfg_tune_nom | input | 24 | Tuning word loaded at reset |
| cfg_tune_min | input | 24 | Lower bound for the tuning word |
| cfg_tune_max | input | 24 | Upper bound for the tuning word |
| rd_vld | output | 1 | One-cycle pulse: `rd_bit` holds a newly read bit |
| rd_bit | output | 1 | Bit read from the buffer |
| fill | output | 10 | Number of unread bits |
| tune_word | output | 24 | Current read-rate tuning word |
| ovf_flag | output | 1 | Sticky: a write was dropped on a full buffer |
| udf_flag | output | 1 | Sticky: a read was dropped on an empty buffer |

## Verification
On every cycle the assertions check the following:
- reads are held off before the half-full start and never occur without an accumulator carry or from an empty buffer;
- the start condition and both error flags stay set once raised;
- a dropped write leaves a full buffer full;
- the tuning word stays within its bounds and moves by at most one per cycle.

Only the bench scenarios can show the rest:
- the modular occupancy arithmetic at specific pointer pairs, including the pair that wraps through address 0;
- the order of the bits read out;
- the read rate produced by a given tuning word;
- the direction the loop steers when the writer is faster and when it is slower.

// File: rtl/esp_pkg.sv
package esp_pkg;

    localparam int unsigned ESP_ADDR_W      = 10;
    localparam int unsigned ESP_PHASE_W     = 24;
    localparam int unsigned ESP_LOOP_PERIOD = 256;

    // Direction decided by one occupancy comparison
    typedef enum logic [1:0] {
        TREND_FLAT = 2'd0,
        TREND_UP   = 2'd1,
        TREND_DOWN = 2'd2
    } trend_e;

endpackage

// File: rtl/esp_fill_diff.sv
module esp_fill_diff #(
    parameter int unsigned ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] wr_ptr,
    input  logic [ADDR_W-1:0] rd_ptr,
    output logic [ADDR_W-1:0] fill
);

    // Subtracting at pointer width discards the borrow, which gives the modular distance
    always_comb begin
        fill = wr_ptr - rd_ptr;
    end

endmodule

// File: rtl/esp_bit_store.sv
module esp_bit_store #(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic              wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic              rdata
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/esp_rate_gen.sv
module esp_rate_gen
    import esp_pkg::*;
#(
    parameter int unsigned PHASE_W     = ESP_PHASE_W,
    parameter int unsigned ADDR_W      = ESP_ADDR_W,
    parameter int unsigned LOOP_PERIOD = ESP_LOOP_PERIOD
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [ADDR_W-1:0]  fill,
    input  logic [PHASE_W-1:0] cfg_nom,
    input  logic [PHASE_W-1:0] cfg_min,
    input  logic [PHASE_W-1:0] cfg_max,
    output logic [PHASE_W-1:0] tune,
    output logic               strobe
);

    localparam int unsigned CNT_W = (LOOP_PERIOD > 1) ? $clog2(LOOP_PERIOD) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOOP_PERIOD - 1);

    typedef struct packed {
        logic [PHASE_W-1:0] acc;
        logic [PHASE_W-1:0] tune;
        logic [CNT_W-1:0]   cnt;
        logic [ADDR_W-1:0]  prev;
    } rg_state_t;

    rg_state_t rg_q, rg_d;
    logic               carry_w;
    logic [PHASE_W-1:0] sum_w;
    logic [PHASE_W-1:0] cand_w;
    logic               tick_w;
    trend_e             trend_w;

    always_comb begin
        rg_d = rg_q;

        // Phase accumulator: a carry out of the top bit marks a read opportunity
        {carry_w, sum_w} = {1'b0, rg_q.acc} + {1'b0, rg_q.tune};
        rg_d.acc = sum_w;

        // Comparison interval
        tick_w   = (rg_q.cnt == CNT_LAST);
        rg_d.cnt = tick_w ? '0 : rg_q.cnt + 1'b1;

        trend_w = TREND_FLAT;
        if (tick_w) begin
            rg_d.prev = fill;
            if (run) begin
                if (fill > rg_q.prev) begin
                    trend_w = TREND_UP;
                end else if (fill < rg_q.prev) begin
                    trend_w = TREND_DOWN;
                end
            end
        end

        // Single step, then hold within the configured window
        cand_w = rg_q.tune;
        if (trend_w == TREND_UP && rg_q.tune < cfg_max) begin
            cand_w = rg_q.tune + 1'b1;
        end else if (trend_w == TREND_DOWN && rg_q.tune > cfg_min) begin
            cand_w = rg_q.tune - 1'b1;
        end
        if (cand_w < cfg_min) begin
            cand_w = cfg_min;
        end else if (cand_w > cfg_max) begin
            cand_w = cfg_max;
        end
        rg_d.tune = cand_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q.acc  <= '0;
            rg_q.tune <= cfg_nom;
            rg_q.cnt  <= '0;
            rg_q.prev <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign tune   = rg_q.tune;
    assign strobe = carry_w;

endmodule

// File: rtl/esp_elastic_store.sv
module esp_elastic_store
    import esp_pkg::*;
#(
    parameter int unsigned ADDR_W      = ESP_ADDR_W,
    parameter int unsigned PHASE_W     = ESP_PHASE_W,
    parameter int unsigned LOOP_PERIOD = ESP_LOOP_PERIOD
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_bit,
    input  logic [PHASE_W-1:0] cfg_tune_nom,
    input  logic [PHASE_W-1:0] cfg_tune_min,
    input  logic [PHASE_W-1:0] cfg_tune_max,
    output logic               rd_vld,
    output logic               rd_bit,
    output logic [ADDR_W-1:0]  fill,
    output logic [PHASE_W-1:0] tune_word,
    output logic               ovf_flag,
    output logic               udf_flag
);

    localparam int unsigned       DEPTH     = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] FULL_FILL = ADDR_W'(DEPTH - 1);
    localparam logic [ADDR_W-1:0] HALF_FILL = ADDR_W'(DEPTH / 2);

    typedef struct packed {
        logic [ADDR_W-1:0] wr_ptr;
        logic [ADDR_W-1:0] rd_ptr;
        logic              run;
        logic              ovf;
        logic              udf;
        logic              rd_vld;
        logic              rd_bit;
    } es_state_t;

    es_state_t s_q, s_d;
    logic [ADDR_W-1:0] fill_w;
    logic              rd_strobe;
    logic              mem_rdata;
    logic              wr_go;
    logic              rd_go;

    esp_fill_diff #(.ADDR_W(ADDR_W)) u_fill (
        .wr_ptr (s_q.wr_ptr),
        .rd_ptr (s_q.rd_ptr),
        .fill   (fill_w)
    );

    esp_bit_store #(.ADDR_W(ADDR_W)) u_store (
        .clk   (clk),
        .we    (wr_go),
        .waddr (s_q.wr_ptr),
        .wdata (wr_bit),
        .raddr (s_q.rd_ptr),
        .rdata (mem_rdata)
    );

    esp_rate_gen #(
        .PHASE_W     (PHASE_W),
        .ADDR_W      (ADDR_W),
        .LOOP_PERIOD (LOOP_PERIOD)
    ) u_rate (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (s_q.run),
        .fill    (fill_w),
        .cfg_nom (cfg_tune_nom),
        .cfg_min (cfg_tune_min),
        .cfg_max (cfg_tune_max),
        .tune    (tune_word),
        .strobe  (rd_strobe)
    );

    always_comb begin
        s_d        = s_q;
        s_d.rd_vld = 1'b0;

        wr_go = wr_en && (fill_w != FULL_FILL);
        rd_go = rd_strobe && s_q.run && (fill_w != '0);

        if (wr_go) begin
            s_d.wr_ptr = s_q.wr_ptr + 1'b1;
        end else if (wr_en) begin
            s_d.ovf = 1'b1;
        end

        if (rd_go) begin
            s_d.rd_ptr = s_q.rd_ptr + 1'b1;
            s_d.rd_vld = 1'b1;
            s_d.rd_bit = mem_rdata;
        end else if (rd_strobe && s_q.run) begin
            s_d.udf = 1'b1;
        end

        // Reads start once the buffer has reached half full for the first time
        if (fill_w >= HALF_FILL) begin
            s_d.run = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_vld   = s_q.rd_vld;
    assign rd_bit   = s_q.rd_bit;
    assign fill     = fill_w;
    assign ovf_flag = s_q.ovf;
    assign udf_flag = s_q.udf;

endmodule

// File: rtl/esp_elastic_store_chk.sv
module esp_elastic_store_chk #(
    parameter int unsigned ADDR_W  = 10,
    parameter int unsigned PHASE_W = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  fill,
    input logic               rd_vld,
    input logic               ovf_flag,
    input logic               udf_flag,
    input logic               run,
    input logic               strobe,
    input logic [PHASE_W-1:0] tune,
    input logic [PHASE_W-1:0] cfg_min,
    input logic [PHASE_W-1:0] cfg_max
);

    localparam logic [ADDR_W-1:0] FULL_FILL = '1;

    // R4
    no_early_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> !rd_vld);

    // R4
    run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run) |-> run);

    // R3
    read_on_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |-> $past(strobe));

    // R8
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fill) == '0) |-> !rd_vld);

    // R8
    udf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(udf_flag) |-> udf_flag);

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ovf_flag) |-> ovf_flag);

    // R7
    full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en && (fill == FULL_FILL)) && !rd_vld) |-> (fill == FULL_FILL));

    // R6
    tune_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_min) <= $past(cfg_max)) |->
            (tune >= $past(cfg_min) && tune <= $past(cfg_max)));

    // R5
    tune_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tune) >= $past(cfg_min) && $past(tune) <= $past(cfg_max)) |->
            (tune == $past(tune) || tune == $past(tune) + 1'b1 || tune == $past(tune) - 1'b1));

endmodule

bind esp_elastic_store esp_elastic_store_chk #(
    .ADDR_W  (ADDR_W),
    .PHASE_W (PHASE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .fill     (fill),
    .rd_vld   (rd_vld),
    .ovf_flag (ovf_flag),
    .udf_flag (udf_flag),
    .run      (s_q.run),
    .strobe   (rd_strobe),
    .tune     (tune_word),
    .cfg_min  (cfg_tune_min),
    .cfg_max  (cfg_tune_max)
);

// File: tb/test_esp_elastic_store.sv
`timescale 1ns/1ps
module test_esp_elastic_store;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_bit = 1'b0;
    logic [23:0] cfg_nom = 24'h800000;
    logic [23:0] cfg_min = 24'h800000;
    logic [23:0] cfg_max = 24'h800000;
    logic        rd_vld;
    logic        rd_bit;
    logic [9:0]  fill;
    logic [23:0] tune_word;
    logic        ovf_flag;
    logic        udf_flag;

    logic [9:0]  fd_wr;
    logic [9:0]  fd_rd;
    logic [9:0]  fd_fill;

    int n_cmp = 0;
    int n_bad = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    bit done = 1'b0;
    bit model_q [$];
    logic [23:0] t_peak;

    always #5 clk = ~clk;

    esp_elastic_store i_esp_elastic_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_bit       (wr_bit),
        .cfg_tune_nom (cfg_nom),
        .cfg_tune_min (cfg_min),
        .cfg_tune_max (cfg_max),
        .rd_vld       (rd_vld),
        .rd_bit       (rd_bit),
        .fill         (fill),
        .tune_word    (tune_word),
        .ovf_flag     (ovf_flag),
        .udf_flag     (udf_flag)
    );

    esp_fill_diff #(.ADDR_W(10)) i_fill_diff (
        .wr_ptr (fd_wr),
        .rd_ptr (fd_rd),
        .fill   (fd_fill)
    );

    // {write pointer, read pointer, expected occupancy}
    localparam logic [29:0] FILL_VEC [8] = '{
        {10'd489,  10'd241, 10'd248},
        {10'd127,  10'd890, 10'd261},
        {10'd0,    10'd0,   10'd0},
        {10'd0,    10'd1,   10'd1023},
        {10'd1023, 10'd0,   10'd1023},
        {10'd5,    10'd5,   10'd0},
        {10'd512,  10'd0,   10'd512},
        {10'd3,    10'd515, 10'd512}
    };

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // One clock: drive at a falling edge, update the model, sample at the next falling edge
    task automatic tick(input bit we);
        bit b;
        bit taken;
        bit exp_b;
        logic [9:0] exp_fill;
        b      = ^(wr_cnt & 32'h29) ^ wr_cnt[6];
        wr_en  = we;
        wr_bit = b;
        taken  = we && (fill != 10'd1023);
        @(negedge clk);
        if (taken) begin
            model_q.push_back(b);
            wr_cnt++;
        end
        if (rd_vld) begin
            rd_cnt++;
            if (model_q.size() == 0) begin
                check(1'b0, "R2 read from empty model", 1, 0);
            end else begin
                exp_b = model_q.pop_front();
                check(rd_bit == exp_b, "R2 read order", rd_bit, exp_b);
            end
        end
        exp_fill = 10'(wr_cnt - rd_cnt);
        check(fill == exp_fill, "R1 fill tracks writes minus reads", fill, exp_fill);
    endtask

    task automatic apply_reset(input logic [23:0] nom, input logic [23:0] lo, input logic [23:0] hi);
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        cfg_nom = nom;
        cfg_min = lo;
        cfg_max = hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wr_cnt = 0;
        rd_cnt = 0;
        model_q.delete();
        // R9 reset state
        check(fill == 10'd0, "R9 reset fill", fill, 0);
        check(rd_vld == 1'b0, "R9 reset rd_vld", rd_vld, 0);
        check(ovf_flag == 1'b0 && udf_flag == 1'b0, "R9 reset flags", {ovf_flag, udf_flag}, 0);
        check(tune_word == nom, "R9 reset tune", tune_word, nom);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        // R1: modular occupancy arithmetic from the vector table
        for (int i = 0; i < 8; i++) begin
            fd_wr = FILL_VEC[i][29:20];
            fd_rd = FILL_VEC[i][19:10];
            #1;
            check(fd_fill == FILL_VEC[i][9:0], "R1 modular fill vector", fd_fill, FILL_VEC[i][9:0]);
        end

        // Phase B: start threshold and half-rate reading
        apply_reset(24'h800000, 24'h800000, 24'h800000);
        for (int i = 0; i < 511; i++) tick(1'b1);
        check(rd_cnt == 0, "R4 no reads below half full", rd_cnt, 0);
        for (int i = 0; i < 600; i++) tick(1'b1);
        check(rd_cnt >= 295 && rd_cnt <= 301, "R3 half-rate tuning gives read every two clocks", rd_cnt, 299);
        check(tune_word == 24'h800000, "R6 pinned window holds tune", tune_word, 24'h800000);
        check(ovf_flag == 1'b0, "R7 no overflow before full", ovf_flag, 0);

        // Phase C: stop the reader and overfill
        cfg_min = 24'h000000;
        cfg_max = 24'h000000;
        for (int i = 0; i < 420; i++) tick(1'b1);
        check(tune_word == 24'h000000, "R6 tune pulled into narrowed window", tune_word, 0);
        check(fill == 10'd1023, "R7 full buffer ignores writes", fill, 1023);
        check(ovf_flag == 1'b1, "R7 overflow flag set", ovf_flag, 1);
        check(udf_flag == 1'b0, "R8 no underflow yet", udf_flag, 0);

        // Phase D: fastest reader drains to empty
        cfg_min = 24'hFFFFFF;
        cfg_max = 24'hFFFFFF;
        for (int i = 0; i < 1100; i++) tick(1'b0);
        check(fill == 10'd0, "R8 empty buffer stays empty", fill, 0);
        check(udf_flag == 1'b1, "R8 underflow flag set", udf_flag, 1);
        check(ovf_flag == 1'b1, "R7 overflow flag sticky", ovf_flag, 1);
        check(rd_cnt == wr_cnt, "R8 reads equal accepted writes", rd_cnt, wr_cnt);

        // Phase E: loop direction, writer faster then writer stopped
        apply_reset(24'h010000, 24'h000100, 24'hFFFFFF);
        for (int i = 0; i < 1100; i++) tick(1'b1);
        t_peak = tune_word;
        check(t_peak > 24'h010000, "R5 rising fill raises tune", t_peak, 24'h010001);
        for (int i = 0; i < 2048; i++) tick(1'b0);
        check(tune_word < t_peak, "R5 falling fill lowers tune", tune_word, t_peak - 1);

        // R6: window forced to a single value
        cfg_min = 24'h001234;
        cfg_max = 24'h001234;
        tick(1'b0);
        tick(1'b0);
        check(tune_word == 24'h001234, "R6 clamp to single value", tune_word, 24'h001234);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule